// File: doc/BRIEF.md
# Display Event Interrupt Register

This block holds one 32-bit interrupt register for a display controller, plus a companion status word. Three event sources share the register: frame completion, the start of vertical sync and the end of vertical sync. Each source has an enable bit and a sticky pending bit in the same word. The controller's timing logic reports each event with a single-cycle strobe. Any pending bit whose enable is also set drives the registered interrupt line.

Software clears pending bits by writing zeros to them. The usual pattern is to read the register and write back the same value with its low byte cleared. This acknowledges every pending event and leaves the enables as they were. The same write can also turn off single sources, for example the end-of-sync enable after a one-shot wait. A separate status word shows which display channel raised the most recent event, so one handler can serve both the main and the sub panel.

Top module: `disp_irq_reg`

## Requirements
- R1: After reset the control word, the status word and the interrupt output are all zero.
- R2: A write loads the enables from write data bit 10 (frame end), bit 9 (sync start) and bit 8 (sync end). They read back at the same positions in the control word from the cycle after the write.
- R3: A strobe on frame end, sync start or sync end sets pending bit 2, 1 or 0 respectively. The bit stays set with no further strobes and no writes.
- R4: A write with 0 at a pending bit position clears that pending bit when no strobe for that source arrives in the same cycle.
- R5: A write with 1 at a pending bit position leaves that bit unchanged; it neither sets nor clears it.
- R6: A strobe in the same cycle as a write that would clear its pending bit leaves the bit set.
- R7: The interrupt output is registered. It equals the OR over the three sources of (pending AND enable) as seen in the control word in the same cycle.
- R8: Writing back a read value with bits 7:0 forced to zero clears every pending bit and keeps the enables. Clearing bit 8 in that same write disables only the sync-end source.
- R9: Bit 10 of the status word holds the channel of the last cycle that carried any strobe: 1 for the sub channel, 0 for the main channel. It holds its value in cycles with no strobe.
- R10: Every control and status bit other than those named above reads zero. A write of all zeros leaves no source enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Data for the control word |
| evt_frame_end | input | 1 | Frame completion strobe |
| evt_vs_start | input | 1 | Vertical sync start strobe |
| evt_vs_end | input | 1 | Vertical sync end strobe |
| evt_is_sub | input | 1 | Channel of the strobes in this cycle (1 = sub) |
| ctl_rdata | output | 32 | Control word: enables and pending bits |
| stat_rdata | output | 32 | Status word: channel flag at bit 10 |
| irq | output | 1 | Registered interrupt request |

## Verification
Each source is first strobed alone, with its enable set and then cleared. This shows that the bit positions are not swapped and that masking works per source. Acknowledge writes are tried in three forms: low byte zeroed, all ones, and zeroed with the sync-end enable dropped. Together they separate clear-on-zero from clear-on-one behaviour and from enable loss. Strobes that land in the same cycle as a clearing write test that the event takes priority. A long pseudo-random run then mixes writes, strobes and channel tags, and is compared every cycle against a behavioural model.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned PEND_LSB = 0;
  localparam int unsigned EN_LSB   = 8;
  localparam int unsigned SUB_BIT  = 10;

  // next value of one pending bit: zero-write clears, one-write holds, event wins
  function automatic logic pend_next(input logic cur, input logic we,
                                     input logic wbit, input logic evt);
    logic kept;
    kept = we ? (cur & wbit) : cur;
    return kept | evt;
  endfunction

  function automatic logic irq_of(input logic [NUM_SRC-1:0] pend,
                                  input logic [NUM_SRC-1:0] en);
    return |(pend & en);
  endfunction
endpackage

// File: rtl/disp_irq_pend_bit.sv
module disp_irq_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic evt,
  output logic pend_d,
  output logic pend_q
);
  import disp_irq_pkg::*;

  assign pend_d = pend_next(pend_q, wr_en, wr_bit, evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q);
  p_evt_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit && evt) |=> pend_q);
  p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit && !evt) |=> !pend_q);
  p_one_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit && !evt) |=> pend_q == $past(pend_q));
endmodule

// File: rtl/disp_irq_enables.sv
module disp_irq_enables #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] en_d,
  output logic [N-1:0] en_q
);
  assign en_d = wr_en ? wr_bits : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == $past(wr_bits));
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/disp_irq_src_flag.sv
module disp_irq_src_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic any_evt,
  input  logic is_sub,
  output logic sub_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sub_q <= 1'b0;
    else if (any_evt) sub_q <= is_sub;
  end

  p_src_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> sub_q == $past(is_sub));
  p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(sub_q));
endmodule

// File: rtl/disp_irq_reg.sv
module disp_irq_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        evt_frame_end,
  input  logic        evt_vs_start,
  input  logic        evt_vs_end,
  input  logic        evt_is_sub,
  output logic [31:0] ctl_rdata,
  output logic [31:0] stat_rdata,
  output logic        irq
);
  import disp_irq_pkg::*;

  localparam int unsigned N = NUM_SRC;

  // source index 2 = frame end, 1 = sync start, 0 = sync end
  logic [N-1:0] evt_vec;
  logic [N-1:0] pend_d, pend_q;
  logic [N-1:0] en_d, en_q;
  logic         any_evt;
  logic         sub_q;
  logic         irq_q;

  assign evt_vec = {evt_frame_end, evt_vs_start, evt_vs_end};
  assign any_evt = |evt_vec;

  for (genvar g = 0; g < N; g++) begin : g_pend
    disp_irq_pend_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bit (wr_data[PEND_LSB+g]),
      .evt    (evt_vec[g]),
      .pend_d (pend_d[g]),
      .pend_q (pend_q[g])
    );
  end

  disp_irq_enables #(.N(N)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[EN_LSB +: N]),
    .en_d    (en_d),
    .en_q    (en_q)
  );

  disp_irq_src_flag u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_evt (any_evt),
    .is_sub  (evt_is_sub),
    .sub_q   (sub_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_of(pend_d, en_d);
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[PEND_LSB +: N] = pend_q;
    ctl_rdata[EN_LSB +: N]   = en_q;
    stat_rdata = '0;
    stat_rdata[SUB_BIT] = sub_q;
  end

  assign irq = irq_q;

  p_irq_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(ctl_rdata[PEND_LSB +: N] & ctl_rdata[EN_LSB +: N]));
  p_ack_keeps_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == ctl_rdata && !any_evt) |=> $stable(ctl_rdata));
  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ctl_rdata) <= 6) && ($countones(stat_rdata) <= 1));
endmodule

// File: tb/test_disp_irq_reg.sv
module test_disp_irq_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        evt_frame_end = 1'b0, evt_vs_start = 1'b0, evt_vs_end = 1'b0;
  logic        evt_is_sub = 1'b0;
  logic [31:0] ctl_rdata, stat_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;

  // behavioural model state
  bit m_fe_p, m_vs_p, m_ve_p;
  bit m_fe_e, m_vs_e, m_ve_e;
  bit m_sub;

  always #5 clk = ~clk;

  disp_irq_reg i_disp_irq_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt_frame_end(evt_frame_end), .evt_vs_start(evt_vs_start),
    .evt_vs_end(evt_vs_end), .evt_is_sub(evt_is_sub),
    .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata), .irq(irq)
  );

  function automatic logic [31:0] m_ctl();
    logic [31:0] v = 0;
    v[10] = m_fe_e; v[9] = m_vs_e; v[8] = m_ve_e;
    v[2] = m_fe_p;  v[1] = m_vs_p; v[0] = m_ve_p;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    check({req, " ctl"}, ctl_rdata, m_ctl());
    check({req, " stat"}, stat_rdata, {21'd0, m_sub, 10'd0});
    check({req, " irq R7"}, {31'd0, irq},
          {31'd0, (m_fe_p & m_fe_e) | (m_vs_p & m_vs_e) | (m_ve_p & m_ve_e)});
  endtask

  // one clock: apply inputs, update model at the edge, compare after it
  task automatic step(input bit we, input logic [31:0] wd, input bit fe,
                      input bit vs, input bit ve, input bit sub, input string req);
    wr_en = we; wr_data = wd;
    evt_frame_end = fe; evt_vs_start = vs; evt_vs_end = ve; evt_is_sub = sub;
    @(posedge clk);
    if (we) begin
      m_fe_p = m_fe_p & wd[2]; m_vs_p = m_vs_p & wd[1]; m_ve_p = m_ve_p & wd[0];
      m_fe_e = wd[10]; m_vs_e = wd[9]; m_ve_e = wd[8];
    end
    m_fe_p |= fe; m_vs_p |= vs; m_ve_p |= ve;
    if (fe || vs || ve) m_sub = sub;
    @(negedge clk);
    wr_en = 1'b0; evt_frame_end = 1'b0; evt_vs_start = 1'b0; evt_vs_end = 1'b0;
    compare_all(req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] lfsr;
    repeat (2) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R3 single events with no enables: pending sets, irq stays low
    step(0, 0, 1, 0, 0, 0, "R3 frame end pend bit2");
    check("R3 bit2", ctl_rdata, 32'h4);
    idle("R3 sticky");
    step(0, 0, 0, 1, 0, 0, "R3 vs start bit1");
    step(0, 0, 0, 0, 1, 0, "R3 vs end bit0");
    check("R3 all pend", ctl_rdata, 32'h7);
    // R5 write ones keeps pending; R2 enables load
    step(1, 32'h0000_0707, 0, 0, 0, 0, "R2 R5 enable all keep pend");
    check("R2 readback", ctl_rdata, 32'h707);
    check("R7 irq high", {31'd0, irq}, 32'h1);
    // R8 acknowledge: low byte zero, drop sync-end enable
    step(1, ctl_rdata & 32'hFFFF_FF00 & ~32'h100, 0, 0, 0, 0, "R8 ack drop vs end");
    check("R8 enables kept", ctl_rdata, 32'h600);
    check("R7 irq low after ack", {31'd0, irq}, 32'h0);
    // masked source: sync end pending with enable off leaves irq low
    step(0, 0, 0, 0, 1, 1, "R7 masked vs end");
    check("R7 masked irq", {31'd0, irq}, 32'h0);
    check("R9 sub flag", stat_rdata, 32'h400);
    // R4 clear with zero, R5 one-write does not set
    step(1, 32'h0000_0600, 0, 0, 0, 0, "R4 zero clears");
    step(1, 32'h0000_0607, 0, 0, 0, 0, "R5 one does not set");
    check("R5 no set", ctl_rdata, 32'h600);
    // R6 event concurrent with clearing write
    step(0, 0, 1, 0, 0, 0, "R3 fe again");
    step(1, 32'h0000_0600, 1, 0, 0, 0, "R6 event beats clear");
    check("R6 kept", ctl_rdata, 32'h604);
    check("R9 main flag", stat_rdata, 32'h0);
    idle("R9 flag hold");
    // R10 all-zero write
    step(1, 32'h0, 0, 0, 0, 1, "R10 zero write");
    check("R10 zero", ctl_rdata, 32'h0);
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R10 spare bits read zero");
    check("R10 only defined bits", ctl_rdata, 32'h700);

    // mixed pseudo-random run
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3] & lfsr[7], {lfsr[31:11], lfsr[10:8], lfsr[7:3], lfsr[2:0] ^ lfsr[18:16]},
           lfsr[12] & lfsr[4], lfsr[13] & lfsr[5], lfsr[14] & lfsr[6], lfsr[20],
           "R3 R4 R5 R6 R9 mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule